// File: doc/BRIEF.md
# Float-to-Int32 Conversion Unit

This block turns one IEEE-754 floating-point operand, in single or double precision, into a signed 32-bit integer. It performs five operations: nearest-even rounding, truncation, rounding up, rounding down, and rounding by the mode held in the control/status word. The caller presents the operand, a precision select, an operation code and the current 32-bit control/status word together with a one-cycle strobe. One clock later the unit returns the integer, the updated control/status word, a writeback enable and a trap request.

The unit sorts the operand into zero, normal or unsupported. Subnormal, infinite and NaN operands are unsupported. It checks the operand against the int32 range, rounds the magnitude, and then updates the exception fields of the control/status word. Unsupported and out-of-range operands do not saturate. They raise the unimplemented-operation cause and request a trap. When a trap is requested, the destination is left untouched and the floating-point exception code is driven out.

Top module: `f2i_conv_unit`

## Requirements
- R1: The outputs are registered. `out_done` is high for exactly the one cycle that follows a cycle with `in_valid` high, and is low at every other time. `out_wb`, `out_trap` and `out_exc_code` are nonzero only while `out_done` is high. Reset clears every output to zero.
- R2: The control/status word uses this layout: bits 1:0 are the rounding mode, bits 6:2 the sticky flags (inexact flag at bit 2), bits 11:7 the enables (inexact enable at bit 7), and bits 17:12 the cause field (inexact cause at bit 12, unimplemented cause at bit 17). Each conversion returns the input word with bits 17:12 cleared. All other bits are copied unchanged, except that flag bits can only be set, never cleared.
- R3: `in_dbl`=1 takes the operand from `in_bits[63:0]` as a double. `in_dbl`=0 takes it from `in_bits[31:0]` as a single. A subnormal, infinite or NaN operand sets bit 17, requests a trap and suppresses the writeback.
- R4: An operand at or above +2^31, or below -2^31, sets bit 17 and traps. Exactly -2^31 converts to 0x80000000. If a rounded result does not fit in int32, the same trap is raised.
- R5: Operation codes: 0 rounds to nearest-even, 1 rounds toward zero, 2 rounds toward +infinity, 3 rounds toward -infinity. Code 4 uses the control/status bits 1:0 (0 nearest-even, 1 toward zero, 2 up, 3 down). Codes 5 to 7 behave as code 4.
- R6: Nearest-even rounding sends an exact half to the even integer.
- R7: For codes 0 and 1, an inexact result sets cause bit 12. If enable bit 7 is set, the unit traps without a writeback. Otherwise it sets flag bit 2 and writes the result.
- R8: Codes 2, 3 and 4 report no inexact condition. They always write an in-range result.
- R9: On a trap, `out_wb` is 0, `out_result` keeps its previous value and `out_exc_code` is 15. On a writeback, `out_exc_code` is 0.
- R10: Zero of either sign converts to 0, with no cause bit set, and is written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Start strobe, one cycle per conversion |
| in_dbl | input | 1 | 1 selects double precision, 0 selects single |
| in_op | input | 3 | Operation code |
| in_bits | input | 64 | Operand bits |
| in_csr | input | 32 | Current control/status word |
| out_done | output | 1 | Result-valid pulse |
| out_result | output | 32 | Signed integer result |
| out_csr | output | 32 | Updated control/status word |
| out_wb | output | 1 | Destination writeback enable |
| out_trap | output | 1 | Trap request |
| out_exc_code | output | 5 | Exception code, 15 on a trap |

## Verification
Every result of this block appears exactly one clock edge after the strobe: the integer, the control/status word, the writeback/trap choice and the exception code are all registered at that single edge. The bench drives the strobe on a falling edge. It samples all outputs on the following falling edge, once that one registering edge has passed, and then drops the strobe. In the idle cycle after a conversion, the bench checks that the pulse outputs return to zero and that the result holds. A trapping conversion is compared against the result captured before it, which confirms that the destination is unchanged.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    parameter int INT_W      = 32;
    parameter int CSR_W      = 32;
    parameter int SGL_EXP_W  = 8;
    parameter int SGL_FRAC_W = 23;
    parameter int DBL_EXP_W  = 11;
    parameter int DBL_FRAC_W = 52;
    parameter int EXC_W      = 5;

    localparam int MANT_W  = DBL_FRAC_W + 1;
    localparam int EXP_IW  = DBL_EXP_W + 2;
    localparam int SGL_W   = SGL_EXP_W + SGL_FRAC_W + 1;
    localparam int DBL_W   = DBL_EXP_W + DBL_FRAC_W + 1;

    // control/status word field positions
    localparam int RM_LO         = 0;
    localparam int FLAG_INEXACT  = 2;
    localparam int FLAG_LO       = 2;
    localparam int FLAG_HI       = 6;
    localparam int EN_INEXACT    = 7;
    localparam int EN_LO         = 7;
    localparam int EN_HI         = 11;
    localparam int CAUSE_LO      = 12;
    localparam int CAUSE_HI      = 17;
    localparam int CAUSE_INEXACT = 12;
    localparam int CAUSE_UNIMPL  = 17;

    localparam logic [CSR_W-1:0] CAUSE_MASK =
        ((CSR_W'(1) << (CAUSE_HI - CAUSE_LO + 1)) - CSR_W'(1)) << CAUSE_LO;

    localparam logic [EXC_W-1:0] EXC_FPE = EXC_W'(15);

    typedef enum logic [2:0] {
        OP_NEAREST = 3'd0,
        OP_TOZERO  = 3'd1,
        OP_CEIL    = 3'd2,
        OP_FLOOR   = 3'd3,
        OP_DYNAMIC = 3'd4
    } conv_op_e;

    typedef enum logic [1:0] {
        RM_NE = 2'd0,
        RM_TZ = 2'd1,
        RM_UP = 2'd2,
        RM_DN = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        CLS_ZERO    = 2'd0,
        CLS_NORMAL  = 2'd1,
        CLS_SPECIAL = 2'd2
    } opnd_cls_e;

    typedef struct packed {
        logic               done;
        logic               wb;
        logic               trap;
        logic [EXC_W-1:0]   exc;
        logic [INT_W-1:0]   result;
        logic [CSR_W-1:0]   csr;
    } conv_state_t;

endpackage

// File: rtl/f2i_fmt_decode.sv
module f2i_fmt_decode
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0]      fp_bits,
    output logic                       sign_o,
    output opnd_cls_e                  cls_o,
    output logic signed [EXP_IW-1:0]   exp_o,
    output logic [MANT_W-1:0]          mant_o
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic [EXP_W-1:0]  field_e;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        field_e = fp_bits[EXP_W+FRAC_W-1:FRAC_W];
        frac    = fp_bits[FRAC_W-1:0];
        sign_o  = fp_bits[EXP_W+FRAC_W];
        exp_o   = $signed(EXP_IW'(field_e)) - $signed(EXP_IW'(BIAS));
        mant_o  = MANT_W'({1'b1, frac}) << (MANT_W - 1 - FRAC_W);
        if (field_e == '0)
            cls_o = (frac == '0) ? CLS_ZERO : CLS_SPECIAL;
        else if (field_e == '1)
            cls_o = CLS_SPECIAL;
        else
            cls_o = CLS_NORMAL;
    end
endmodule

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [DBL_W-1:0]           opnd_bits,
    input  logic                       is_dbl,
    output logic                       sign_o,
    output opnd_cls_e                  cls_o,
    output logic signed [EXP_IW-1:0]   exp_o,
    output logic [MANT_W-1:0]          mant_o
);
    logic                     s_sign, d_sign;
    opnd_cls_e                s_cls, d_cls;
    logic signed [EXP_IW-1:0] s_exp, d_exp;
    logic [MANT_W-1:0]        s_mant, d_mant;

    f2i_fmt_decode #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W)) u_sgl (
        .fp_bits (opnd_bits[SGL_W-1:0]),
        .sign_o  (s_sign),
        .cls_o   (s_cls),
        .exp_o   (s_exp),
        .mant_o  (s_mant)
    );

    f2i_fmt_decode #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W)) u_dbl (
        .fp_bits (opnd_bits),
        .sign_o  (d_sign),
        .cls_o   (d_cls),
        .exp_o   (d_exp),
        .mant_o  (d_mant)
    );

    always_comb begin
        sign_o = is_dbl ? d_sign : s_sign;
        cls_o  = is_dbl ? d_cls  : s_cls;
        exp_o  = is_dbl ? d_exp  : s_exp;
        mant_o = is_dbl ? d_mant : s_mant;
    end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  logic                       sign_i,
    input  logic signed [EXP_IW-1:0]   exp_i,
    input  logic [MANT_W-1:0]          mant_i,
    input  rmode_e                     rm_i,
    output logic [INT_W-1:0]           result_o,
    output logic                       inexact_o,
    output logic                       fits_o
);
    localparam int SH_W    = INT_W + MANT_W;
    localparam int SHAMT_W = $clog2(INT_W + 2);
    localparam logic signed [EXP_IW-1:0] E_TOP  = EXP_IW'(INT_W - 1);
    localparam logic signed [EXP_IW-1:0] E_NEG1 = -EXP_IW'(1);
    localparam logic [INT_W:0] LIMIT = (INT_W + 1)'(1) << (INT_W - 1);

    logic [SH_W-1:0]    wide;
    logic [SHAMT_W-1:0] shamt;
    logic [INT_W-1:0]   ipart;
    logic               rbit, sticky, inc, pre_out;
    logic [INT_W:0]     mag;

    always_comb begin
        shamt   = '0;
        wide    = '0;
        pre_out = 1'b0;
        if (exp_i > E_TOP) begin
            pre_out = 1'b1;
        end else if (exp_i == E_TOP) begin
            // only an exact -2^INT_W-1 survives at the top exponent
            pre_out = !sign_i || (mant_i[MANT_W-2:0] != '0);
        end
        if (exp_i >= E_NEG1 && !pre_out) begin
            shamt = SHAMT_W'(exp_i + 1);
            wide  = {{INT_W{1'b0}}, mant_i} << shamt;
        end

        if (exp_i < E_NEG1) begin
            ipart  = '0;
            rbit   = 1'b0;
            sticky = 1'b1;
        end else begin
            ipart  = wide[SH_W-1 -: INT_W];
            rbit   = wide[MANT_W-1];
            sticky = |wide[MANT_W-2:0];
        end

        unique case (rm_i)
            RM_NE:   inc = rbit & (sticky | ipart[0]);
            RM_TZ:   inc = 1'b0;
            RM_UP:   inc = (rbit | sticky) & ~sign_i;
            default: inc = (rbit | sticky) & sign_i;
        endcase

        mag       = {1'b0, ipart} + (INT_W + 1)'(inc);
        inexact_o = rbit | sticky;
        fits_o    = !pre_out && (sign_i ? (mag <= LIMIT) : (mag < LIMIT));
        result_o  = sign_i ? INT_W'((INT_W + 1)'(0) - mag) : mag[INT_W-1:0];
    end
endmodule

// File: rtl/f2i_conv_unit.sv
module f2i_conv_unit
    import f2i_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_dbl,
    input  logic [2:0]         in_op,
    input  logic [63:0]        in_bits,
    input  logic [31:0]        in_csr,
    output logic               out_done,
    output logic [31:0]        out_result,
    output logic [31:0]        out_csr,
    output logic               out_wb,
    output logic               out_trap,
    output logic [4:0]         out_exc_code
);
    logic                     u_sign;
    opnd_cls_e                u_cls;
    logic signed [EXP_IW-1:0] u_exp;
    logic [MANT_W-1:0]        u_mant;
    rmode_e                   rm_sel;
    logic [INT_W-1:0]         r_value;
    logic                     r_inexact, r_fits;
    logic                     chk_inexact;
    conv_state_t              st_d, st_q;

    f2i_unpack u_unpack (
        .opnd_bits (in_bits),
        .is_dbl    (in_dbl),
        .sign_o    (u_sign),
        .cls_o     (u_cls),
        .exp_o     (u_exp),
        .mant_o    (u_mant)
    );

    f2i_round u_round (
        .sign_i    (u_sign),
        .exp_i     (u_exp),
        .mant_i    (u_mant),
        .rm_i      (rm_sel),
        .result_o  (r_value),
        .inexact_o (r_inexact),
        .fits_o    (r_fits)
    );

    always_comb begin
        unique case (in_op)
            OP_NEAREST: rm_sel = RM_NE;
            OP_TOZERO:  rm_sel = RM_TZ;
            OP_CEIL:    rm_sel = RM_UP;
            OP_FLOOR:   rm_sel = RM_DN;
            default:    rm_sel = rmode_e'(in_csr[RM_LO +: 2]);
        endcase
        chk_inexact = (in_op == OP_NEAREST) || (in_op == OP_TOZERO);
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.wb   = 1'b0;
        st_d.trap = 1'b0;
        st_d.exc  = '0;
        if (in_valid) begin
            st_d.done = 1'b1;
            st_d.csr  = in_csr & ~CAUSE_MASK;
            if (u_cls == CLS_SPECIAL || (u_cls == CLS_NORMAL && !r_fits)) begin
                st_d.csr[CAUSE_UNIMPL] = 1'b1;
                st_d.trap              = 1'b1;
                st_d.exc               = EXC_FPE;
            end else if (u_cls == CLS_ZERO) begin
                st_d.result = '0;
                st_d.wb     = 1'b1;
            end else if (chk_inexact && r_inexact) begin
                st_d.csr[CAUSE_INEXACT] = 1'b1;
                if (in_csr[EN_INEXACT]) begin
                    st_d.trap = 1'b1;
                    st_d.exc  = EXC_FPE;
                end else begin
                    st_d.csr[FLAG_INEXACT] = 1'b1;
                    st_d.result            = r_value;
                    st_d.wb                = 1'b1;
                end
            end else begin
                st_d.result = r_value;
                st_d.wb     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_done     = st_q.done;
    assign out_result   = st_q.result;
    assign out_csr      = st_q.csr;
    assign out_wb       = st_q.wb;
    assign out_trap     = st_q.trap;
    assign out_exc_code = st_q.exc;
endmodule

// File: rtl/f2i_conv_checker.sv
module f2i_conv_checker
    import f2i_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_csr,
    input logic        out_done,
    input logic [31:0] out_result,
    input logic [31:0] out_csr,
    input logic        out_wb,
    input logic        out_trap,
    input logic [4:0]  out_exc_code
);
    a_r1_done_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);

    a_r1_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_done);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_done |-> (!out_wb && !out_trap && out_exc_code == '0));

    a_r9_write_or_trap: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (out_wb != out_trap));

    a_r9_trap_code: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_exc_code == EXC_FPE));

    a_r9_dest_kept: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> $stable(out_result));

    a_r2_control_copied: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_csr[RM_LO +: 2] == $past(in_csr[RM_LO +: 2]) &&
                      out_csr[EN_HI:EN_LO] == $past(in_csr[EN_HI:EN_LO]) &&
                      out_csr[31:CAUSE_HI+1] == $past(in_csr[31:CAUSE_HI+1])));

    a_r2_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_csr[FLAG_HI:FLAG_LO] & $past(in_csr[FLAG_HI:FLAG_LO]))
                      == $past(in_csr[FLAG_HI:FLAG_LO])));

    a_r3_unimpl_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_csr[CAUSE_UNIMPL]) |-> out_trap);

    a_r7_enabled_inexact_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_csr[CAUSE_INEXACT] && out_csr[EN_INEXACT]) |-> out_trap);
endmodule

bind f2i_conv_unit f2i_conv_checker u_conv_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_csr       (in_csr),
    .out_done     (out_done),
    .out_result   (out_result),
    .out_csr      (out_csr),
    .out_wb       (out_wb),
    .out_trap     (out_trap),
    .out_exc_code (out_exc_code)
);

// File: tb/tb_f2i_conv_unit.sv
`timescale 1ns/1ps
module tb_f2i_conv_unit;
    localparam real CLK_NS = 20.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_dbl = 1'b0;
    logic [2:0]  in_op = '0;
    logic [63:0] in_bits = '0;
    logic [31:0] in_csr = '0;
    logic        out_done, out_wb, out_trap;
    logic [31:0] out_result, out_csr;
    logic [4:0]  out_exc_code;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_NS / 2.0) clk = ~clk;

    f2i_conv_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
        .in_op(in_op), .in_bits(in_bits), .in_csr(in_csr),
        .out_done(out_done), .out_result(out_result), .out_csr(out_csr),
        .out_wb(out_wb), .out_trap(out_trap), .out_exc_code(out_exc_code)
    );

    localparam logic [31:0] C_INX = 32'h0000_1004; // inexact cause + flag
    localparam logic [31:0] C_UNI = 32'h0002_0000; // unimplemented cause

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one conversion; ewb=1 expects a writeback of eres, else a trap
    task automatic conv(input logic dbl, input logic [2:0] op, input logic [63:0] bits,
                        input logic [31:0] csr, input logic ewb,
                        input logic [31:0] eres, input logic [31:0] ecsr,
                        input string req);
        logic [31:0] prev;
        logic [31:0] want;
        prev = out_result;
        @(negedge clk);
        in_valid = 1'b1; in_dbl = dbl; in_op = op; in_bits = bits; in_csr = csr;
        @(negedge clk);
        in_valid = 1'b0;
        want = ewb ? eres : prev;
        chk(out_done == 1'b1, req, "done", 32'(out_done), 32'd1);
        chk(out_wb == ewb, req, "wb", 32'(out_wb), 32'(ewb));
        chk(out_trap == !ewb, req, "trap", 32'(out_trap), 32'(!ewb));
        chk(out_exc_code == (ewb ? 5'd0 : 5'd15), req, "exc_code",
            32'(out_exc_code), ewb ? 32'd0 : 32'd15);
        chk(out_result == want, req, "result", out_result, want);
        chk(out_csr == ecsr, req, "csr", out_csr, ecsr);
    endtask

    task automatic t_reset();
        chk(out_done == 1'b0, "R1", "reset done", 32'(out_done), 0);
        chk(out_result == '0, "R1", "reset result", out_result, 0);
        chk(out_csr == '0, "R1", "reset csr", out_csr, 0);
        chk(!out_wb && !out_trap, "R1", "reset wb/trap", {30'b0, out_wb, out_trap}, 0);
    endtask

    task automatic t_exact_and_zero();
        conv(1'b0, 3'd1, 64'h4040_0000, 32'h5A03_F004, 1'b1, 32'd3, 32'h5A00_0004, "R2");
        conv(1'b0, 3'd0, 64'h0000_0000, 32'h0000_0000, 1'b1, 32'd0, 32'h0, "R10");
        conv(1'b0, 3'd3, 64'h8000_0000, 32'h0001_F000, 1'b1, 32'd0, 32'h0, "R10");
        conv(1'b1, 3'd2, 64'h8000_0000_0000_0000, 32'h0, 1'b1, 32'd0, 32'h0, "R10");
    endtask

    task automatic t_nearest();
        conv(1'b0, 3'd0, 64'h4020_0000, 32'h0, 1'b1, 32'd2, C_INX, "R6");
        conv(1'b1, 3'd0, $realtobits(3.5), 32'h0, 1'b1, 32'd4, C_INX, "R6");
        conv(1'b0, 3'd0, 64'hC020_0000, 32'h0, 1'b1, 32'hFFFF_FFFE, C_INX, "R6");
        conv(1'b0, 3'd0, 64'h3F40_0000, 32'h0, 1'b1, 32'd1, C_INX, "R7");
    endtask

    task automatic t_truncate();
        conv(1'b0, 3'd1, 64'hC020_0000, 32'h0, 1'b1, 32'hFFFF_FFFE, C_INX, "R7");
        conv(1'b0, 3'd1, 64'hBFE0_0000, 32'h0, 1'b1, 32'hFFFF_FFFF, C_INX, "R5");
    endtask

    task automatic t_directed_modes();
        conv(1'b0, 3'd2, 64'hBFE0_0000, 32'h0, 1'b1, 32'hFFFF_FFFF, 32'h0, "R8");
        conv(1'b0, 3'd3, 64'hBFE0_0000, 32'h0, 1'b1, 32'hFFFF_FFFE, 32'h0, "R8");
        conv(1'b0, 3'd4, 64'h3FC0_0000, 32'h3, 1'b1, 32'd1, 32'h3, "R5");
        conv(1'b0, 3'd4, 64'h3FC0_0000, 32'h2, 1'b1, 32'd2, 32'h2, "R5");
        conv(1'b0, 3'd4, 64'h3FC0_0000, 32'h0, 1'b1, 32'd2, 32'h0, "R5");
        conv(1'b0, 3'd4, 64'h3FC0_0000, 32'h1, 1'b1, 32'd1, 32'h1, "R8");
        conv(1'b0, 3'd7, 64'h3FC0_0000, 32'h3, 1'b1, 32'd1, 32'h3, "R5");
    endtask

    task automatic t_inexact_trap();
        conv(1'b0, 3'd1, 64'h4040_0000, 32'h0, 1'b1, 32'd3, 32'h0, "R7");
        conv(1'b0, 3'd0, 64'h4020_0000, 32'h0000_0080, 1'b0, 32'd0, 32'h0000_1080, "R9");
        conv(1'b0, 3'd0, 64'h4040_0000, 32'h0000_0080, 1'b1, 32'd3, 32'h0000_0080, "R7");
    endtask

    task automatic t_special();
        conv(1'b0, 3'd1, 64'h7F80_0000, 32'h0, 1'b0, 32'd0, C_UNI, "R3");
        conv(1'b1, 3'd4, 64'h7FF8_0000_0000_0000, 32'h0, 1'b0, 32'd0, C_UNI, "R3");
        conv(1'b0, 3'd0, 64'h0000_0001, 32'h0000_0004, 1'b0, 32'd0, C_UNI | 32'h4, "R3");
        conv(1'b1, 3'd1, 64'h0000_0000_0000_0001, 32'h0, 1'b0, 32'd0, C_UNI, "R3");
    endtask

    task automatic t_range();
        conv(1'b0, 3'd1, 64'h4F00_0000, 32'h0, 1'b0, 32'd0, C_UNI, "R4");
        conv(1'b0, 3'd1, 64'hCF00_0000, 32'h0, 1'b1, 32'h8000_0000, 32'h0, "R4");
        conv(1'b1, 3'd0, $realtobits(2147483647.5), 32'h0, 1'b0, 32'd0, C_UNI, "R4");
        conv(1'b1, 3'd1, $realtobits(2147483647.5), 32'h0, 1'b1, 32'h7FFF_FFFF, C_INX, "R4");
        conv(1'b1, 3'd2, $realtobits(-2147483648.5), 32'h0, 1'b0, 32'd0, C_UNI, "R4");
        conv(1'b1, 3'd4, $realtobits(2147483647.0), 32'h0, 1'b1, 32'h7FFF_FFFF, 32'h0, "R4");
    endtask

    task automatic t_idle_hold();
        logic [31:0] keep;
        conv(1'b0, 3'd1, 64'h4040_0000, 32'h0, 1'b1, 32'd3, 32'h0, "R1");
        keep = out_result;
        @(negedge clk);
        chk(out_done == 1'b0, "R1", "idle done", 32'(out_done), 0);
        chk(!out_wb && !out_trap, "R1", "idle wb/trap", {30'b0, out_wb, out_trap}, 0);
        chk(out_result == keep, "R1", "idle result", out_result, keep);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_exact_and_zero();
        t_nearest();
        t_truncate();
        t_directed_modes();
        t_inexact_trap();
        t_special();
        t_range();
        t_idle_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule